// File: doc/BRIEF.md
# Video Port Sync and Data Timing Generator

This block is the timing engine of a parallel video and data port. It produces the port clock and three frame-sync lines from programmable line and frame geometry, and it paces the data bus. Everything runs on one system clock. The port clock comes out at half that rate, so every port-clock period spans two system cycles: one holds the sync edge and the other holds the opposite edge.

In capture mode the port is the timing master for an external video source. Sync line 0 acts as horizontal sync and sync line 1 as vertical sync. Data words on the pad are sampled during active video and delivered on a receive strobe. In output mode the same two syncs are produced, and sync line 2 marks active video. One word per active period is pulled from a stream source and driven onto the pad with an output enable. Clock-edge choice, sync polarity and data-edge alignment are separate static controls. The enable takes effect only at a line boundary.

Top module: `vid_port_timing`

## Requirements
- R1: `pclk_o` toggles every system cycle and rests at `clk_pol_i` while idle and in reset. The sync lines change only on the system edge that drives `pclk_o` to its active level: rising when `clk_pol_i`=0, falling when it is 1.
- R2: A line lasts `line_len_i` port periods. Horizontal sync (`sync_o[0]`) is active for the first `hsync_w_i` periods of each line.
- R3: A frame lasts `frame_lines_i` lines. Vertical sync (`sync_o[1]`) is active for the whole of its first `vsync_w_i` lines.
- R4: `sync_pol_i`=0 makes the sync lines active high. With 1 they are active low, and every inactive line rests at the level of `sync_pol_i`.
- R5: Active video is the set of periods with column >= `hblank_i` and line >= `vblank_i`. In output mode (`mode_i`=1) `sync_o[2]` is active exactly then. In capture mode (`mode_i`=0) it stays inactive.
- R6: With `same_edge_i`=0, `pad_oe_o` and `pad_data_o` update on the edge opposite the sync edge, half a period after `sync_o[2]`. With `same_edge_i`=1 they update on the sync edge itself. `pad_oe_o` never rises before `sync_o[2]` is active.
- R7: In output mode exactly one word is taken per active period. `tx_rd_o` strobes on the system edge that loads the `tx_data_i` word onto `pad_data_o`, and the words leave in stream order.
- R8: In capture mode `pad_oe_o` stays low. Each active period yields exactly one `rx_vld_o` pulse, and `rx_data_o` holds the value of `pad_data_i` at the sampling edge, which is the edge opposite the sync edge when `same_edge_i`=0.
- R9: The enable is acted on only at a line boundary. With the enable held from reset, the first horizontal sync (line 0 of a frame) appears at the `line_len_i`-th active port-clock edge. After the enable drops, the port stops at the next boundary with all syncs inactive and `pad_oe_o` low.
- R10: While in reset `pad_oe_o`, `tx_rd_o` and `rx_vld_o` are low, the sync lines rest at their inactive level and `pclk_o` rests at `clk_pol_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the port-clock rate |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Port enable, taken at line boundaries |
| mode_i | input | 1 | 0 capture, 1 output |
| clk_pol_i | input | 1 | 0 active edge rising, 1 falling |
| sync_pol_i | input | 1 | 0 syncs active high, 1 active low |
| same_edge_i | input | 1 | 1 puts data on the sync edge |
| line_len_i | input | HW | Port periods per line |
| hsync_w_i | input | HW | Horizontal sync width in periods |
| hblank_i | input | HW | Blank periods at line start |
| frame_lines_i | input | VW | Lines per frame |
| vsync_w_i | input | VW | Vertical sync width in lines |
| vblank_i | input | VW | Blank lines at frame start |
| tx_data_i | input | DW | Next word to transmit |
| tx_rd_o | output | 1 | Word taken this cycle |
| pad_data_i | input | DW | Data bus input from pads |
| pad_data_o | output | DW | Data bus output to pads |
| pad_oe_o | output | 1 | Data bus output enable |
| rx_data_o | output | DW | Captured word |
| rx_vld_o | output | 1 | Captured word valid |
| pclk_o | output | 1 | Port clock |
| sync_o | output | 3 | Sync lines: 0 horizontal, 1 vertical, 2 active video |

## Verification
The bench tracks column and line from the first horizontal sync, and it sweeps both clock polarities, both sync polarities and both data-edge alignments. It checks that the output enable follows the active-video sync by exactly half a period, or by zero. A design that used the wrong edge would lose or duplicate the first word of every line. The bench counts port edges from reset to the first horizontal sync, which exposes an enable acted on mid-line or a line length off by one. It then drops the enable and confirms that the bus is released and the syncs fall idle. In capture mode it matches every receive pulse against the pad value present at the sampling edge, so a sample taken one edge early shows up as a data mismatch.

// File: rtl/vpt_pkg.sv
package vpt_pkg;
  typedef enum logic {
    VP_CAPTURE = 1'b0,
    VP_OUTPUT  = 1'b1
  } vp_mode_e;
endpackage

// File: rtl/vpt_phase.sv
module vpt_phase (
  input  logic clk,
  input  logic rst,
  input  logic clk_pol_i,
  output logic tick_o,
  output logic pclk_o
);
  logic ph_q;
  logic pclk_q;

  // phase 0 is the system edge that carries the sync (active) edge
  assign tick_o = ~ph_q;
  assign pclk_o = pclk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= 1'b0;
      pclk_q <= clk_pol_i;
    end else begin
      ph_q   <= ~ph_q;
      pclk_q <= tick_o ? ~clk_pol_i : clk_pol_i;
    end
  end

  // R1
  pclk_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (pclk_q != $past(pclk_q)));

  // R1
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> (pclk_q == clk_pol_i));
endmodule

// File: rtl/vpt_scan_ctr.sv
module vpt_scan_ctr #(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          en_i,
  input  logic [HW-1:0] line_len_i,
  input  logic [VW-1:0] frame_lines_i,
  output logic [HW-1:0] h_nxt_o,
  output logic [VW-1:0] v_nxt_o,
  output logic          run_nxt_o,
  output logic          run_q_o
);
  logic [HW-1:0] hcnt_q;
  logic [VW-1:0] vcnt_q;
  logic          run_q;
  logic          line_end;
  logic          frame_end;

  assign run_q_o = run_q;

  always_comb begin
    line_end  = (hcnt_q == line_len_i - 1'b1);
    frame_end = (vcnt_q == frame_lines_i - 1'b1);
    h_nxt_o   = line_end ? '0 : hcnt_q + 1'b1;
    run_nxt_o = line_end ? en_i : run_q;
    if (!run_nxt_o)
      v_nxt_o = '0;
    else if (line_end)
      v_nxt_o = (!run_q || frame_end) ? '0 : vcnt_q + 1'b1;
    else
      v_nxt_o = vcnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt_q <= '0;
      vcnt_q <= '0;
      run_q  <= 1'b0;
    end else if (tick_i) begin
      hcnt_q <= h_nxt_o;
      vcnt_q <= v_nxt_o;
      run_q  <= run_nxt_o;
    end
  end

  // R9
  start_on_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(run_q) |-> $past(line_end && tick_i));

  // R9
  stop_on_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(run_q) |-> $past(line_end && tick_i));

  // R2
  col_range_chk: assert property (@(posedge clk) disable iff (rst)
    hcnt_q < line_len_i);
endmodule

// File: rtl/vpt_sync_gen.sv
module vpt_sync_gen
  import vpt_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  vp_mode_e      mode_i,
  input  logic          run_nxt_i,
  input  logic [HW-1:0] h_nxt_i,
  input  logic [VW-1:0] v_nxt_i,
  input  logic [HW-1:0] hsync_w_i,
  input  logic [HW-1:0] hblank_i,
  input  logic [VW-1:0] vsync_w_i,
  input  logic [VW-1:0] vblank_i,
  output logic [2:0]    flag_o,
  output logic          act_q_o,
  output logic          act_nxt_o
);
  logic hs_nxt, vs_nxt, f3_nxt;
  logic hs_q, vs_q, f3_q, act_q;

  always_comb begin
    hs_nxt    = run_nxt_i && (h_nxt_i < hsync_w_i);
    vs_nxt    = run_nxt_i && (v_nxt_i < vsync_w_i);
    act_nxt_o = run_nxt_i && (h_nxt_i >= hblank_i) && (v_nxt_i >= vblank_i);
    f3_nxt    = act_nxt_o && (mode_i == VP_OUTPUT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q  <= 1'b0;
      vs_q  <= 1'b0;
      f3_q  <= 1'b0;
      act_q <= 1'b0;
    end else if (tick_i) begin
      hs_q  <= hs_nxt;
      vs_q  <= vs_nxt;
      f3_q  <= f3_nxt;
      act_q <= act_nxt_o;
    end
  end

  assign flag_o  = {f3_q, vs_q, hs_q};
  assign act_q_o = act_q;

  // R5
  cap_no_frame3_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(tick_i) && ($past(mode_i) == VP_CAPTURE)) |-> !f3_q);

  // R5
  frame3_in_active_chk: assert property (@(posedge clk) disable iff (rst)
    f3_q |-> act_q);
endmodule

// File: rtl/vpt_data_path.sv
module vpt_data_path
  import vpt_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          same_edge_i,
  input  vp_mode_e      mode_i,
  input  logic          act_q_i,
  input  logic          act_nxt_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic [DW-1:0] pad_data_i,
  output logic          tx_rd_o,
  output logic [DW-1:0] pad_data_o,
  output logic          pad_oe_o,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_vld_o
);
  logic          data_edge;
  logic          drive_act;
  logic          is_out;
  logic          oe_q;
  logic [DW-1:0] dout_q;
  logic [DW-1:0] rx_q;
  logic          rxv_q;

  always_comb begin
    data_edge = same_edge_i ? tick_i : ~tick_i;
    drive_act = same_edge_i ? act_nxt_i : act_q_i;
    is_out    = (mode_i == VP_OUTPUT);
    tx_rd_o   = !rst && data_edge && drive_act && is_out;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q   <= 1'b0;
      dout_q <= '0;
    end else if (data_edge) begin
      oe_q <= drive_act && is_out;
      if (tx_rd_o) dout_q <= tx_data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxv_q <= 1'b0;
      rx_q  <= '0;
    end else begin
      rxv_q <= data_edge && act_q_i && !is_out;
      if (data_edge && act_q_i && !is_out) rx_q <= pad_data_i;
    end
  end

  assign pad_oe_o   = oe_q;
  assign pad_data_o = dout_q;
  assign rx_data_o  = rx_q;
  assign rx_vld_o   = rxv_q;

  // R6
  oe_after_sync_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_q) |-> act_q_i);

  // R8
  cap_bus_released_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_i == VP_CAPTURE && $past(mode_i) == VP_CAPTURE) |-> !oe_q);

  // R8
  rx_pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    rxv_q |=> !rxv_q);
endmodule

// File: rtl/vid_port_timing.sv
module vid_port_timing
  import vpt_pkg::*;
#(
  parameter int DW = 16,
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic          mode_i,
  input  logic          clk_pol_i,
  input  logic          sync_pol_i,
  input  logic          same_edge_i,
  input  logic [HW-1:0] line_len_i,
  input  logic [HW-1:0] hsync_w_i,
  input  logic [HW-1:0] hblank_i,
  input  logic [VW-1:0] frame_lines_i,
  input  logic [VW-1:0] vsync_w_i,
  input  logic [VW-1:0] vblank_i,
  input  logic [DW-1:0] tx_data_i,
  output logic          tx_rd_o,
  input  logic [DW-1:0] pad_data_i,
  output logic [DW-1:0] pad_data_o,
  output logic          pad_oe_o,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_vld_o,
  output logic          pclk_o,
  output logic [2:0]    sync_o
);
  localparam int NSYNC = 3;

  vp_mode_e      mode;
  logic          tick;
  logic [HW-1:0] h_nxt;
  logic [VW-1:0] v_nxt;
  logic          run_nxt;
  logic          run_q;
  logic [2:0]    flags;
  logic          act_q;
  logic          act_nxt;

  assign mode = vp_mode_e'(mode_i);

  vpt_phase u_phase (
    .clk       (clk),
    .rst       (rst),
    .clk_pol_i (clk_pol_i),
    .tick_o    (tick),
    .pclk_o    (pclk_o)
  );

  vpt_scan_ctr #(.HW(HW), .VW(VW)) u_ctr (
    .clk           (clk),
    .rst           (rst),
    .tick_i        (tick),
    .en_i          (en_i),
    .line_len_i    (line_len_i),
    .frame_lines_i (frame_lines_i),
    .h_nxt_o       (h_nxt),
    .v_nxt_o       (v_nxt),
    .run_nxt_o     (run_nxt),
    .run_q_o       (run_q)
  );

  vpt_sync_gen #(.HW(HW), .VW(VW)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .tick_i    (tick),
    .mode_i    (mode),
    .run_nxt_i (run_nxt),
    .h_nxt_i   (h_nxt),
    .v_nxt_i   (v_nxt),
    .hsync_w_i (hsync_w_i),
    .hblank_i  (hblank_i),
    .vsync_w_i (vsync_w_i),
    .vblank_i  (vblank_i),
    .flag_o    (flags),
    .act_q_o   (act_q),
    .act_nxt_o (act_nxt)
  );

  vpt_data_path #(.DW(DW)) u_data (
    .clk         (clk),
    .rst         (rst),
    .tick_i      (tick),
    .same_edge_i (same_edge_i),
    .mode_i      (mode),
    .act_q_i     (act_q),
    .act_nxt_i   (act_nxt),
    .tx_data_i   (tx_data_i),
    .pad_data_i  (pad_data_i),
    .tx_rd_o     (tx_rd_o),
    .pad_data_o  (pad_data_o),
    .pad_oe_o    (pad_oe_o),
    .rx_data_o   (rx_data_o),
    .rx_vld_o    (rx_vld_o)
  );

  for (genvar g = 0; g < NSYNC; g++) begin : g_pin
    assign sync_o[g] = flags[g] ^ sync_pol_i;
  end

  // R9
  sync_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
    (flags[0] || flags[1]) |-> run_q);

  // R6
  oe_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pad_oe_o) |-> (run_q && flags[2]));
endmodule

// File: tb/vid_port_timing_tb_top.sv
module vid_port_timing_tb_top;
  localparam int DW = 16;
  localparam int HW = 12;
  localparam int VW = 11;
  localparam int NCFG = 4;
  // line_len, hsync_w, hblank, lines, vsync_w, vblank, mode, clk_pol, sync_pol, same_edge
  localparam int TBL [NCFG][10] = '{
    '{12, 2, 4, 6, 1, 2, 1, 0, 0, 0},
    '{10, 3, 3, 5, 2, 1, 1, 1, 1, 1},
    '{16, 1, 5, 4, 1, 1, 1, 0, 1, 1},
    '{ 9, 2, 2, 5, 2, 2, 0, 1, 0, 0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, mode = 1'b0, cpol = 1'b0, spol = 1'b0, same = 1'b0;
  logic [HW-1:0] ll = 12, hsw = 1, hb = 1;
  logic [VW-1:0] nl = 4, vsw = 1, vb = 1;
  logic [DW-1:0] txcnt;
  logic [DW-1:0] din = '0;
  logic          tx_rd, oe, rxv, pclk;
  logic [DW-1:0] dout, rxd;
  logic [2:0]    sync;

  int total = 0, bad = 0, cyc = 0;

  always #10 clk = ~clk;

  vid_port_timing #(.DW(DW), .HW(HW), .VW(VW)) dut_i (
    .clk(clk), .rst(rst), .en_i(en), .mode_i(mode), .clk_pol_i(cpol),
    .sync_pol_i(spol), .same_edge_i(same), .line_len_i(ll), .hsync_w_i(hsw),
    .hblank_i(hb), .frame_lines_i(nl), .vsync_w_i(vsw), .vblank_i(vb),
    .tx_data_i(txcnt), .tx_rd_o(tx_rd), .pad_data_i(din), .pad_data_o(dout),
    .pad_oe_o(oe), .rx_data_o(rxd), .rx_vld_o(rxv), .pclk_o(pclk), .sync_o(sync)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) txcnt <= '0;
    else if (tx_rd) txcnt <= txcnt + 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    din = din + 1'b1;
    @(negedge clk);
  endtask

  initial begin
    wait (cyc > 150000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCFG; c++) begin
      int edges, rxn, words, e_h, e_v, e_f3, e_ph, e_oe, e_dat, e_rx, h, v, ex_rx, e_off;
      bit found, prev_act, act, out;
      logic [2:0] s_edge;
      logic [DW-1:0] last;
      ll = HW'(TBL[c][0]); hsw = HW'(TBL[c][1]); hb = HW'(TBL[c][2]);
      nl = VW'(TBL[c][3]); vsw = VW'(TBL[c][4]); vb = VW'(TBL[c][5]);
      mode = TBL[c][6][0]; cpol = TBL[c][7][0]; spol = TBL[c][8][0];
      same = TBL[c][9][0];
      out = mode;
      en = 1'b1;
      rst = 1'b1;
      repeat (3) @(negedge clk);
      // R10 reset state, R4 idle level
      chk(!oe && !tx_rd && !rxv && sync == {3{spol}} && pclk == cpol,
          "R10 R4 reset state", int'({oe, tx_rd, rxv, sync, pclk}),
          int'({3'b000, {3{spol}}, cpol}));
      rst = 1'b0;
      edges = 0; found = 0;
      for (int i = 0; i < 4 * int'(ll) + 8 && !found; i++) begin
        step();
        if (pclk != cpol) begin
          edges++;
          if (sync[0] ^ spol) found = 1;
        end
      end
      // R9 enable taken at first line boundary
      chk(found && edges == int'(ll), "R9 first hsync edge", edges, int'(ll));
      e_h = 0; e_v = 0; e_f3 = 0; e_ph = 0; e_oe = 0; e_dat = 0; e_rx = 0;
      rxn = 0; words = 0; h = 0; v = 0; prev_act = 0; last = '1;
      for (int p = 0; p < 2 * int'(ll) * int'(nl); p++) begin
        act = (h >= int'(hb)) && (v >= int'(vb));
        // sync edge sample
        if (pclk == cpol) e_ph++;
        if ((sync[0] ^ spol) != (h < int'(hsw))) e_h++;
        if ((sync[1] ^ spol) != (v < int'(vsw))) e_v++;
        if ((sync[2] ^ spol) != (act && out)) e_f3++;
        if (oe != ((same ? act : prev_act) && out)) e_oe++;
        if (same && oe) begin
          if (dout != last + 1'b1) e_dat++;
          last = dout; words++;
        end
        if (rxv) begin rxn++; if (rxd != din) e_rx++; end
        s_edge = sync;
        step();
        // opposite edge sample
        if (pclk != cpol) e_ph++;
        if (sync != s_edge) e_ph++;
        if (oe != (act && out)) e_oe++;
        if (!same && oe) begin
          if (dout != last + 1'b1) e_dat++;
          last = dout; words++;
        end
        if (rxv) begin rxn++; if (rxd != din) e_rx++; end
        step();
        prev_act = act;
        h++;
        if (h == int'(ll)) begin h = 0; v = (v == int'(nl) - 1) ? 0 : v + 1; end
      end
      chk(e_ph == 0, "R1 sync moves only on active edge", e_ph, 0);
      chk(e_h == 0, "R2 R4 horizontal sync", e_h, 0);
      chk(e_v == 0, "R3 R4 vertical sync", e_v, 0);
      chk(e_f3 == 0, "R5 active video sync", e_f3, 0);
      chk(e_oe == 0, "R6 output enable edge", e_oe, 0);
      ex_rx = 2 * (int'(nl) - int'(vb)) * (int'(ll) - int'(hb));
      if (out) begin
        chk(e_dat == 0, "R7 word order", e_dat, 0);
        chk(words == ex_rx, "R7 word count", words, ex_rx);
      end else begin
        chk(rxn == ex_rx, "R8 capture count", rxn, ex_rx);
        chk(e_rx == 0, "R8 capture data", e_rx, 0);
      end
      if (c == 0) begin
        en = 1'b0;
        repeat (4 * int'(ll)) step();
        e_off = 0;
        for (int i = 0; i < 2 * int'(ll); i++) begin
          if (oe || tx_rd || sync != {3{spol}}) e_off++;
          step();
        end
        // R9 stop at boundary, bus released
        chk(e_off == 0, "R9 disable idles port", e_off, 0);
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule